// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block models a byte-wide static RAM in which every word has a shadow nonvolatile copy. Normally the block behaves as a plain SRAM behind an active-low chip enable, output enable and write enable, with a bidirectional data bus. All of these are sampled on a system clock. Two bulk transfers exist. STORE snapshots the whole SRAM into the shadow array. RECALL first clears the SRAM and then reloads it from the shadow array.

No dedicated pins start a transfer. Software starts one by issuing six reads to fixed addresses in order. The first five addresses are common to both transfers, and the sixth picks STORE or RECALL. Any write, and any read to an address that does not fit the sequence, breaks it. A RECALL also runs by itself when reset is released, which models power-up. While a transfer runs, `busy` is high, reads do not drive the bus and writes are dropped. The transfer moves one word per clock.

Top module: `nvsram_store_recall`

## Requirements
- R1: While reset is held, and for exactly 2*DEPTH clock cycles after it is released, `busy` is high. During that time the automatic RECALL reloads the SRAM from the shadow array.
- R2: A write takes effect when a clock edge samples `ceN`=0 and `weN`=0 with `busy` low, and it stores `data` at `addr`. For a read, hold `ceN`=0, `oeN`=0, `weN`=1 and `addr` over one clock edge. After that edge the bus carries the word at `addr`.
- R3: The block drives `data` only when `busy` is low, `ceN`=0, `oeN`=0 and `weN`=1.
- R4: A read access begins on a cycle where `ceN` is low, `weN` is high, and `ceN` was high on the previous cycle. Six read accesses in a row trigger a transfer. The first five must go to 15'h2A51, 15'h15A2, 15'h4C33, 15'h33C4 and 15'h0F05. The sixth goes to 15'h70F6 for STORE or to 15'h0F87 for RECALL. Only the low ADDR_W bits of these addresses are compared. `busy` rises after the edge that samples the sixth access. For a STORE it stays high for STORE_CYCLES cycles (STORE_CYCLES > DEPTH).
- R5: A STORE copies every SRAM word into the shadow array, and the shadow contents survive a reset.
- R6: A RECALL holds `busy` high for 2*DEPTH cycles. It clears the SRAM and then replaces every word with the shadow copy, so writes made after the last STORE are lost.
- R7: A RECALL leaves the shadow array unchanged, so back-to-back RECALLs give the same contents.
- R8: A read access to an address that does not fit the sequence aborts it, and no transfer starts.
- R9: Any write cycle resets the sequence detector, and a write never starts a transfer.
- R10: While `busy` is high, writes are dropped and reads do not drive `data`.
- R11: An aborting read to the first sequence address counts as the first step of a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; release models power-up |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address |
| data | inout | 8 | Bidirectional data bus |
| busy | output | 1 | High during STORE or RECALL |

## Verification
The assertions assume that the bus-control inputs are synchronous to `clk` and never unknown. They also assume that nothing outside the block drives `data` while the block is driving it. The bench changes inputs only on falling edges. It drives the data bus only during write cycles, when `weN` is low, so the block's output is off. Each access is followed by one idle cycle with `ceN` high, so every read counts as a separate access for the detector.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef struct packed {
    logic wrSram;
    logic clrWord;
    logic storeWord;
    logic recallWord;
  } strobe_t;

  localparam int SEQ_LEN = 5;
  localparam logic [14:0] SEQ_ADDR [SEQ_LEN] = '{15'h2A51, 15'h15A2, 15'h4C33, 15'h33C4, 15'h0F05};
  localparam logic [14:0] STORE_ADDR  = 15'h70F6;
  localparam logic [14:0] RECALL_ADDR = 15'h0F87;
endpackage

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STORE_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] idx
);
  localparam int TW = $clog2(STORE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] LAST_IDX = '1;
  localparam logic [TW-1:0] TMR_END = TW'(STORE_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_RCL_CLR, ST_RCL_CPY} state_t;

  state_t state;
  logic [ADDR_W-1:0] cnt;
  logic [TW-1:0] tmr;
  logic copied;
  logic [2:0] stage;
  logic ceNq;
  logic readStart, wrCycle;
  logic [ADDR_W-1:0] expAddr, firstAddr;

  assign readStart = !ceN && weN && ceNq && (state == ST_IDLE);
  assign wrCycle   = !ceN && !weN;
  assign firstAddr = SEQ_ADDR[0][ADDR_W-1:0];

  always_comb begin
    expAddr = firstAddr;
    for (int i = 0; i < SEQ_LEN; i++)
      if (stage == 3'(i)) expAddr = SEQ_ADDR[i][ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_RCL_CLR;
      cnt    <= '0;
      tmr    <= '0;
      copied <= 1'b0;
      stage  <= '0;
      ceNq   <= 1'b1;
    end else begin
      ceNq <= ceN;
      unique case (state)
        ST_IDLE: begin
          if (wrCycle) begin
            stage <= '0;
          end else if (readStart) begin
            if (stage == 3'(SEQ_LEN)) begin
              stage <= '0;
              if (addr == STORE_ADDR[ADDR_W-1:0]) begin
                state  <= ST_STORE;
                cnt    <= '0;
                tmr    <= '0;
                copied <= 1'b0;
              end else if (addr == RECALL_ADDR[ADDR_W-1:0]) begin
                state <= ST_RCL_CLR;
                cnt   <= '0;
              end else if (addr == firstAddr) begin
                stage <= 3'd1;
              end
            end else if (addr == expAddr) begin
              stage <= stage + 3'd1;
            end else begin
              stage <= (addr == firstAddr) ? 3'd1 : 3'd0;
            end
          end
        end
        ST_STORE: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) copied <= 1'b1;
          if (tmr != TMR_END) tmr <= tmr + 1'b1;
          if (copied && tmr == TMR_END) state <= ST_IDLE;
        end
        ST_RCL_CLR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= ST_RCL_CPY;
        end
        ST_RCL_CPY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state != ST_IDLE);
  assign idx             = cnt;
  assign strb.wrSram     = (state == ST_IDLE) && wrCycle;
  assign strb.clrWord    = (state == ST_RCL_CLR);
  assign strb.recallWord = (state == ST_RCL_CPY);
  assign strb.storeWord  = (state == ST_STORE) && !copied;
endmodule

// File: rtl/nvsram_datapath.sv
module nvsram_datapath
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              busy,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              driveEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] sram   [DEPTH];
  logic [7:0] shadow [DEPTH];
  logic [7:0] rdData;

  always_ff @(posedge clk) begin
    if (strb.clrWord)         sram[idx]  <= '0;
    else if (strb.recallWord) sram[idx]  <= shadow[idx];
    else if (strb.wrSram)     sram[addr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (strb.storeWord) shadow[idx] <= sram[idx];
  end

  always_ff @(posedge clk) rdData <= sram[addr];

  assign dataOut = rdData;
  assign driveEn = !busy && !ceN && !oeN && weN;
endmodule

// File: rtl/nvsram_store_recall.sv
module nvsram_store_recall
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STORE_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [7:0]        data,
  output logic              busy
);
  strobe_t strb;
  logic [ADDR_W-1:0] idx;
  logic [7:0] dataOut;
  logic driveEn;

  nvsram_ctrl #(.ADDR_W(ADDR_W), .STORE_CYCLES(STORE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .addr(addr),
    .busy(busy), .strb(strb), .idx(idx)
  );

  nvsram_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .strb(strb), .idx(idx), .addr(addr), .ceN(ceN), .oeN(oeN),
    .weN(weN), .busy(busy), .dataIn(data), .dataOut(dataOut), .driveEn(driveEn)
  );

  assign data = driveEn ? dataOut : 8'hzz;
endmodule

// File: rtl/nvsram_store_recall_chk.sv
module nvsram_store_recall_chk
  import nvsram_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    ceN,
  input logic    weN,
  input logic    busy,
  input strobe_t strb
);
  // R10: no SRAM write strobe reaches the array during a transfer
  p_no_write_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.wrSram);

  // R2: at most one array action per cycle
  p_single_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSram, strb.clrWord, strb.storeWord, strb.recallWord}));

  // R4: shadow copying only happens while busy is shown
  p_store_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeWord |-> busy);

  // R9: a write cycle never starts a transfer
  p_write_no_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !weN && !busy) |=> !busy);

  // R6: reload from shadow is always preceded by the clear pass
  p_clear_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.recallWord) |-> $past(strb.clrWord));
endmodule

bind nvsram_store_recall nvsram_store_recall_chk chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .busy(busy), .strb(strb)
);

// File: tb/nvsram_store_recall_tb.sv
module nvsram_store_recall_tb_top;
  localparam int AW = 6;
  localparam int SC = 100;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] drv = '0;
  logic drvEn = 1'b0;
  wire  [7:0] data;
  logic busy;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [DEPTH];

  localparam logic [14:0] TB_SEQ [5] = '{15'h2A51, 15'h15A2, 15'h4C33, 15'h33C4, 15'h0F05};
  localparam logic [AW-1:0] A_STORE  = 15'h70F6 & 15'h3F;
  localparam logic [AW-1:0] A_RECALL = 15'h0F87 & 15'h3F;

  assign data = drvEn ? drv : 8'hzz;

  always #2.5 clk = ~clk;

  nvsram_store_recall #(.ADDR_W(AW), .STORE_CYCLES(SC)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .data(data), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic powerCycle(input string req);
    int n;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b1, req, busy, 1);
    rstN = 1'b1;
    waitIdle(n);
    check(n == 2 * DEPTH, req, n, 2 * DEPTH);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
    addr = a; drv = v; drvEn = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; drvEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    @(negedge clk);
    #0.5 v = data;
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic fillModel(input int seed);
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = 8'((a * 37 + seed * 11 + 5) ^ seed);
      wr(AW'(a), model[a]);
    end
  endtask

  task automatic checkAll(input string req);
    logic [7:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), v);
      check(v === model[a], req, v, model[a]);
    end
  endtask

  // Issue the five shared reads and the final one; returns busy cycles seen.
  task automatic runSeq(input logic [AW-1:0] last, output int n);
    logic [7:0] v;
    for (int i = 0; i < 5; i++) rd(TB_SEQ[i][AW-1:0], v);
    addr = last; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    waitIdle(n);
  endtask

  task automatic tReset();
    powerCycle("R1");
    check(busy === 1'b0, "R1", busy, 0);
  endtask

  task automatic tWriteRead();
    logic [7:0] v;
    fillModel(1);
    checkAll("R2");
    addr = 6'd9; ceN = 1'b0; oeN = 1'b1; weN = 1'b1;
    @(negedge clk);
    #0.5 check(data !== model[9], "R3", data, 8'hzz);
    ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tStore();
    int n;
    fillModel(2);
    runSeq(A_STORE, n);
    check(n == SC, "R4", n, SC);
    for (int a = 0; a < DEPTH; a += 3) wr(AW'(a), 8'hEE);
    powerCycle("R5");
    checkAll("R5");
  endtask

  task automatic tRecall();
    int n;
    for (int a = 0; a < DEPTH; a += 2) wr(AW'(a), 8'h3C);
    runSeq(A_RECALL, n);
    check(n == 2 * DEPTH, "R6", n, 2 * DEPTH);
    checkAll("R6");
    runSeq(A_RECALL, n);
    check(n == 2 * DEPTH, "R7", n, 2 * DEPTH);
    checkAll("R7");
  endtask

  task automatic tAbortRead();
    logic [7:0] v;
    wr(6'd4, 8'h99);
    for (int i = 0; i < 3; i++) rd(TB_SEQ[i][AW-1:0], v);
    rd(6'd20, v);
    rd(TB_SEQ[3][AW-1:0], v);
    rd(TB_SEQ[4][AW-1:0], v);
    addr = A_STORE; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R8", busy, 0);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    rd(6'd4, v);
    check(v === 8'h99, "R8", v, 8'h99);
  endtask

  task automatic tAbortWrite();
    int n;
    logic [7:0] v;
    for (int i = 0; i < 3; i++) rd(TB_SEQ[i][AW-1:0], v);
    wr(6'd5, 8'h77);
    rd(TB_SEQ[3][AW-1:0], v);
    rd(TB_SEQ[4][AW-1:0], v);
    addr = A_STORE; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R9", busy, 0);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    // shadow still holds the earlier snapshot: a recall brings it back
    runSeq(A_RECALL, n);
    checkAll("R9");
  endtask

  task automatic tRestart();
    int n;
    logic [7:0] v;
    fillModel(3);
    rd(TB_SEQ[0][AW-1:0], v);
    rd(TB_SEQ[1][AW-1:0], v);
    runSeq(A_STORE, n);
    check(n == SC, "R11", n, SC);
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 8'h00);
    runSeq(A_RECALL, n);
    checkAll("R11");
  endtask

  task automatic tBusyBlock();
    int n;
    fillModel(4);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] v;
      rd(TB_SEQ[i][AW-1:0], v);
    end
    addr = A_STORE; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    repeat (3) @(negedge clk);
    addr = 6'd12; drv = ~model[12]; drvEn = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; drvEn = 1'b0;
    @(negedge clk);
    addr = 6'd13; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    #0.5 check(data !== model[13], "R10", data, 8'hzz);
    ceN = 1'b1; oeN = 1'b1;
    waitIdle(n);
    checkAll("R10");
    runSeq(A_RECALL, n);
    checkAll("R10");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #0.5 check(busy === 1'b1, "R1", busy, 1);
    tReset();
    tWriteRead();
    tStore();
    tRecall();
    tAbortRead();
    tAbortWrite();
    tRestart();
    tBusyBlock();
    finishRun();
  end
endmodule